// File: doc/BRIEF.md
# Byte and Pair Register File

This block holds seven 8-bit working registers and lets a controller treat three fixed couples of them as 16-bit values. One command arrives per clock. It can be a register-to-register move whose source and destination are taken from the opcode byte, a 16-bit immediate load of a pair, a swap of the two address pairs, a pair increment or decrement, or an addition of a pair into the address pair with a carry out.

The address pair is always presented as a 16-bit memory address. When a move names memory as its source, the block raises a read request and captures the returned byte into the destination register in the same cycle. When a move names memory as its destination, the block raises a write request and presents the source byte. The one opcode that names memory on both sides is not a move: it raises a halt indication and leaves all state unchanged.

Top module: `regpair_file`

## Requirements
- R1: With `cmd_i`=1 (move), an opcode of the form 01-ddd-sss copies register sss into register ddd at the next clock edge; an opcode whose top two bits differ from 01 changes no register.
- R2: Register codes are 000=B, 001=C, 010=D, 011=E, 100=H, 101=L, 111=A; `rd_data_o` shows the register chosen by `rd_sel_i` and reads 0 for code 110.
- R3: With `cmd_i`=2 (load), pair code 00=BC, 01=DE, 10=HL takes `imm_i`, upper byte into B, D or H and lower byte into C, E or L; `pair_rd_o` shows the pair chosen by `pair_i`, and pair code 11 makes any pair command a no-op and reads 0.
- R4: With `cmd_i`=3 (exchange), the full HL and DE values swap at one clock edge.
- R5: With `cmd_i`=4 (increment) or 5 (decrement), the selected pair changes by one modulo 2^16 and `carry_o` is unchanged.
- R6: With `cmd_i`=6 (add), HL takes the low 16 bits of HL plus the selected pair and `carry_o` takes bit 16 of that sum; no other command changes `carry_o`.
- R7: A move with source code 110 asserts `mem_rd_o` in the same cycle and writes `mem_rdata_i` into the destination; a move with destination code 110 asserts `mem_wr_o` with the source byte on `mem_wdata_o` and writes no register; `hl_addr_o` always shows HL; the two requests are never active together.
- R8: The move opcode 0x76 asserts `halt_o` in the same cycle, raises no memory request and changes no register.
- R9: An asynchronous low on `rst_ni` clears every register and `carry_o` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Command: 0 none, 1 move, 2 load, 3 exchange, 4 increment, 5 decrement, 6 add to HL |
| opcode_i | input | 8 | Move opcode byte |
| pair_i | input | 2 | Pair select for pair commands and pair readout |
| imm_i | input | 16 | Immediate value for load |
| mem_rdata_i | input | 8 | Byte returned for a memory-source move |
| rd_sel_i | input | 3 | Register code for byte readout |
| rd_data_o | output | 8 | Selected register byte |
| pair_rd_o | output | 16 | Selected pair value |
| hl_addr_o | output | 16 | HL as memory address |
| mem_rd_o | output | 1 | Memory read request |
| mem_wr_o | output | 1 | Memory write request |
| mem_wdata_o | output | 8 | Byte to write to memory |
| halt_o | output | 1 | Halt opcode seen |
| carry_o | output | 1 | Carry out of the last add to HL |

## Verification
A memory-source move whose destination is H or L uses HL as the address and overwrites half of HL at the same edge. The bench issues such a move, samples `hl_addr_o` during the request cycle to confirm it still shows the old HL, and then reads HL after the edge to confirm the returned byte landed in the upper half. The address must change only after the edge, never within the request cycle.

// File: rtl/regpair_pkg.sv
package regpair_pkg;
  localparam int DW      = 8;
  localparam int CODE_W  = 3;
  localparam int NREG    = 1 << CODE_W;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_MOVE = 3'd1,
    CMD_LOAD = 3'd2,
    CMD_XCHG = 3'd3,
    CMD_INC  = 3'd4,
    CMD_DEC  = 3'd5,
    CMD_ADD  = 3'd6
  } cmd_e;

  typedef enum logic [1:0] {
    PA_INC = 2'd0,
    PA_DEC = 2'd1,
    PA_ADD = 2'd2
  } pair_op_e;

  localparam logic [CODE_W-1:0] RC_B = 3'd0;
  localparam logic [CODE_W-1:0] RC_C = 3'd1;
  localparam logic [CODE_W-1:0] RC_D = 3'd2;
  localparam logic [CODE_W-1:0] RC_E = 3'd3;
  localparam logic [CODE_W-1:0] RC_H = 3'd4;
  localparam logic [CODE_W-1:0] RC_L = 3'd5;
  localparam logic [CODE_W-1:0] RC_M = 3'd6;
  localparam logic [CODE_W-1:0] RC_A = 3'd7;

  localparam logic [1:0] PR_BC   = 2'd0;
  localparam logic [1:0] PR_DE   = 2'd1;
  localparam logic [1:0] PR_HL   = 2'd2;
  localparam logic [1:0] PR_NONE = 2'd3;

  function automatic logic [CODE_W-1:0] pair_hi(input logic [1:0] p);
    case (p)
      PR_BC:   return RC_B;
      PR_DE:   return RC_D;
      default: return RC_H;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] pair_lo(input logic [1:0] p);
    case (p)
      PR_BC:   return RC_C;
      PR_DE:   return RC_E;
      default: return RC_L;
    endcase
  endfunction
endpackage

// File: rtl/regpair_move_dec.sv
module regpair_move_dec
  import regpair_pkg::*;
(
  input  logic [7:0]        opcode_i,
  output logic              move_o,
  output logic              halt_o,
  output logic              src_mem_o,
  output logic              dst_mem_o,
  output logic [CODE_W-1:0] dst_o,
  output logic [CODE_W-1:0] src_o
);
  logic group_hit;

  assign dst_o     = opcode_i[5:3];
  assign src_o     = opcode_i[2:0];
  assign group_hit = (opcode_i[7:6] == 2'b01);
  // both fields on memory is the halt slot, not a move
  assign halt_o    = group_hit && (dst_o == RC_M) && (src_o == RC_M);
  assign move_o    = group_hit && !halt_o;
  assign src_mem_o = move_o && (src_o == RC_M);
  assign dst_mem_o = move_o && (dst_o == RC_M);
endmodule

// File: rtl/regpair_pair_alu.sv
module regpair_pair_alu
  import regpair_pkg::*;
#(
  parameter int AW = 2 * DW
) (
  input  pair_op_e      op_i,
  input  logic [AW-1:0] a_i,
  input  logic [AW-1:0] b_i,
  output logic [AW-1:0] res_o,
  output logic          carry_o
);
  logic [AW:0] sum;

  always_comb begin
    unique case (op_i)
      PA_INC:  sum = {1'b0, a_i} + (AW+1)'(1);
      PA_DEC:  sum = {1'b0, a_i} - (AW+1)'(1);
      default: sum = {1'b0, a_i} + {1'b0, b_i};
    endcase
  end

  assign res_o   = sum[AW-1:0];
  assign carry_o = (op_i == PA_ADD) && sum[AW];
endmodule

// File: rtl/regpair_bank.sv
module regpair_bank
  import regpair_pkg::*;
#(
  parameter int W = DW,
  parameter int N = NREG
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0]        wr_en_i,
  input  logic [N-1:0][W-1:0] wr_data_i,
  output logic [N-1:0][W-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         q_o[g] <= '0;
      else if (wr_en_i[g]) q_o[g] <= wr_data_i[g];
    end
  end
endmodule

// File: rtl/regpair_file.sv
module regpair_file
  import regpair_pkg::*;
#(
  parameter int W  = DW,
  parameter int AW = 2 * W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    cmd_i,
  input  logic [7:0]    opcode_i,
  input  logic [1:0]    pair_i,
  input  logic [AW-1:0] imm_i,
  input  logic [W-1:0]  mem_rdata_i,
  input  logic [2:0]    rd_sel_i,
  output logic [W-1:0]  rd_data_o,
  output logic [AW-1:0] pair_rd_o,
  output logic [AW-1:0] hl_addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [W-1:0]  mem_wdata_o,
  output logic          halt_o,
  output logic          carry_o
);
  localparam int N = NREG;

  cmd_e                 cmd;
  logic [N-1:0][W-1:0]  q;
  logic [N-1:0][W-1:0]  wr_data;
  logic [N-1:0]         wr_en;
  logic                 dec_move, dec_halt, dec_src_mem, dec_dst_mem;
  logic [CODE_W-1:0]    dec_dst, dec_src;
  logic [CODE_W-1:0]    hi_code, lo_code;
  logic                 pair_ok;
  logic [AW-1:0]        sel_pair, hl, de, alu_res;
  pair_op_e             alu_op;
  logic                 alu_carry, carry_we;

  assign cmd = cmd_e'(cmd_i);

  regpair_move_dec u_dec (
    .opcode_i  (opcode_i),
    .move_o    (dec_move),
    .halt_o    (dec_halt),
    .src_mem_o (dec_src_mem),
    .dst_mem_o (dec_dst_mem),
    .dst_o     (dec_dst),
    .src_o     (dec_src)
  );

  regpair_bank #(.W(W), .N(N)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .q_o       (q)
  );

  assign pair_ok  = (pair_i != PR_NONE);
  assign hi_code  = pair_hi(pair_i);
  assign lo_code  = pair_lo(pair_i);
  assign sel_pair = {q[hi_code], q[lo_code]};
  assign hl       = {q[RC_H], q[RC_L]};
  assign de       = {q[RC_D], q[RC_E]};

  always_comb begin
    unique case (cmd)
      CMD_INC: alu_op = PA_INC;
      CMD_DEC: alu_op = PA_DEC;
      default: alu_op = PA_ADD;
    endcase
  end

  regpair_pair_alu #(.AW(AW)) u_alu (
    .op_i    (alu_op),
    .a_i     (sel_pair),
    .b_i     (hl),
    .res_o   (alu_res),
    .carry_o (alu_carry)
  );

  always_comb begin
    wr_en       = '0;
    wr_data     = q;
    mem_rd_o    = 1'b0;
    mem_wr_o    = 1'b0;
    mem_wdata_o = '0;
    halt_o      = 1'b0;
    carry_we    = 1'b0;
    case (cmd)
      CMD_MOVE: begin
        if (dec_halt) begin
          halt_o = 1'b1;
        end else if (dec_move) begin
          if (dec_dst_mem) begin
            mem_wr_o    = 1'b1;
            mem_wdata_o = q[dec_src];
          end else begin
            wr_en[dec_dst]   = 1'b1;
            mem_rd_o         = dec_src_mem;
            wr_data[dec_dst] = dec_src_mem ? mem_rdata_i : q[dec_src];
          end
        end
      end
      CMD_LOAD: if (pair_ok) begin
        wr_en[hi_code]   = 1'b1;
        wr_en[lo_code]   = 1'b1;
        wr_data[hi_code] = imm_i[AW-1:W];
        wr_data[lo_code] = imm_i[W-1:0];
      end
      CMD_XCHG: begin
        wr_en[RC_H] = 1'b1;  wr_data[RC_H] = q[RC_D];
        wr_en[RC_L] = 1'b1;  wr_data[RC_L] = q[RC_E];
        wr_en[RC_D] = 1'b1;  wr_data[RC_D] = q[RC_H];
        wr_en[RC_E] = 1'b1;  wr_data[RC_E] = q[RC_L];
      end
      CMD_INC, CMD_DEC: if (pair_ok) begin
        wr_en[hi_code]   = 1'b1;
        wr_en[lo_code]   = 1'b1;
        wr_data[hi_code] = alu_res[AW-1:W];
        wr_data[lo_code] = alu_res[W-1:0];
      end
      CMD_ADD: if (pair_ok) begin
        wr_en[RC_H]   = 1'b1;
        wr_en[RC_L]   = 1'b1;
        wr_data[RC_H] = alu_res[AW-1:W];
        wr_data[RC_L] = alu_res[W-1:0];
        carry_we      = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       carry_o <= 1'b0;
    else if (carry_we) carry_o <= alu_carry;
  end

  assign rd_data_o = (rd_sel_i == RC_M) ? '0 : q[rd_sel_i];
  assign pair_rd_o = pair_ok ? sel_pair : '0;
  assign hl_addr_o = hl;

  // R7
  mem_req_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_rd_o, mem_wr_o, halt_o}));

  // R7
  mem_slot_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en[RC_M]);

  // R4
  xchg_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'(CMD_XCHG)) |=> (hl == $past(de)) && (de == $past(hl)));

  // R5
  hl_inc_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'(CMD_INC) && pair_i == PR_HL) |=> (hl == $past(hl) + AW'(1)));

  // R6
  carry_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i != 3'(CMD_ADD)) |=> $stable(carry_o));

  // R8
  halt_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> $stable(q));
endmodule

// File: tb/sim_regpair_file.sv
`timescale 1ns/1ps
module sim_regpair_file;
  localparam logic [2:0] C_NOP = 3'd0, C_MOVE = 3'd1, C_LOAD = 3'd2, C_XCHG = 3'd3,
                         C_INC = 3'd4, C_DEC = 3'd5, C_ADD = 3'd6;

  typedef struct packed {
    logic [2:0]  cmd;
    logic [7:0]  op;
    logic [1:0]  pair;
    logic [15:0] imm;
    logic        chk_byte;
    logic [2:0]  chk_sel;
    logic [15:0] exp;
    logic        exp_c;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{C_LOAD, 8'h00, 2'd0, 16'h1234, 1'b0, 3'd0, 16'h1234, 1'b0, 4'd3}, // R3 BC
    '{C_LOAD, 8'h00, 2'd1, 16'hABCD, 1'b0, 3'd1, 16'hABCD, 1'b0, 4'd3}, // R3 DE
    '{C_LOAD, 8'h00, 2'd2, 16'hFFFF, 1'b0, 3'd2, 16'hFFFF, 1'b0, 4'd3}, // R3 HL
    '{C_INC,  8'h00, 2'd2, 16'h0000, 1'b0, 3'd2, 16'h0000, 1'b0, 4'd5}, // R5 wrap up
    '{C_DEC,  8'h00, 2'd2, 16'h0000, 1'b0, 3'd2, 16'hFFFF, 1'b0, 4'd5}, // R5 wrap down
    '{C_ADD,  8'h00, 2'd0, 16'h0000, 1'b0, 3'd2, 16'h1233, 1'b1, 4'd6}, // R6 carry out
    '{C_ADD,  8'h00, 2'd1, 16'h0000, 1'b0, 3'd2, 16'hBE00, 1'b0, 4'd6}, // R6 no carry
    '{C_XCHG, 8'h00, 2'd0, 16'h0000, 1'b0, 3'd2, 16'hABCD, 1'b0, 4'd4}, // R4 HL side
    '{C_NOP,  8'h00, 2'd0, 16'h0000, 1'b0, 3'd1, 16'hBE00, 1'b0, 4'd4}, // R4 DE side
    '{C_MOVE, 8'h78, 2'd0, 16'h0000, 1'b1, 3'd7, 16'h0012, 1'b0, 4'd1}, // R1 A<-B
    '{C_MOVE, 8'h4F, 2'd0, 16'h0000, 1'b0, 3'd0, 16'h1212, 1'b0, 4'd2}, // R2 C<-A
    '{C_MOVE, 8'h6B, 2'd0, 16'h0000, 1'b0, 3'd2, 16'hAB00, 1'b0, 4'd2}, // R2 L<-E
    '{C_ADD,  8'h00, 2'd2, 16'h0000, 1'b0, 3'd2, 16'h5600, 1'b1, 4'd6}, // R6 HL+HL
    '{C_DEC,  8'h00, 2'd0, 16'h0000, 1'b0, 3'd0, 16'h1211, 1'b1, 4'd5}, // R5 carry kept
    '{C_INC,  8'h00, 2'd3, 16'h0000, 1'b0, 3'd2, 16'h5600, 1'b1, 4'd3}, // R3 pair 11
    '{C_NOP,  8'h00, 2'd0, 16'h0000, 1'b0, 3'd0, 16'h1211, 1'b1, 4'd3}  // R3 BC intact
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  cmd_i = '0;
  logic [7:0]  opcode_i = '0;
  logic [1:0]  pair_i = '0;
  logic [15:0] imm_i = '0;
  logic [7:0]  mem_rdata_i = '0;
  logic [2:0]  rd_sel_i = '0;
  logic [7:0]  rd_data_o;
  logic [15:0] pair_rd_o, hl_addr_o;
  logic        mem_rd_o, mem_wr_o, halt_o, carry_o;
  logic [7:0]  mem_wdata_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  regpair_file u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd_i), .opcode_i(opcode_i), .pair_i(pair_i),
    .imm_i(imm_i), .mem_rdata_i(mem_rdata_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
    .pair_rd_o(pair_rd_o), .hl_addr_o(hl_addr_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .mem_wdata_o(mem_wdata_o), .halt_o(halt_o), .carry_o(carry_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] c, input logic [7:0] op, input logic [1:0] p,
                       input logic [15:0] imm, input logic [7:0] md);
    @(negedge clk);
    cmd_i = c; opcode_i = op; pair_i = p; imm_i = imm; mem_rdata_i = md;
  endtask

  task automatic idle_read(input logic [1:0] p, input logic [2:0] sel);
    @(negedge clk);
    cmd_i = C_NOP; opcode_i = '0; pair_i = p; rd_sel_i = sel;
    #1;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=%h exp=%h", 1'b0, 1'b1);
      summary();
      $finish;
    end
  end

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk);
    #1;
    chk("R9 HL after reset", pair_rd_o | hl_addr_o, 16'h0000);
    chk("R9 carry after reset", {15'd0, carry_o}, 16'h0000);
    chk("R9 requests idle", {13'd0, mem_rd_o, mem_wr_o, halt_o}, 16'h0000);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].cmd, VECS[i].op, VECS[i].pair, VECS[i].imm, 8'h00);
      idle_read(VECS[i].chk_sel[1:0], VECS[i].chk_sel);
      if (VECS[i].chk_byte)
        chk($sformatf("R%0d vec %0d byte", VECS[i].req, i), {8'h00, rd_data_o}, VECS[i].exp);
      else
        chk($sformatf("R%0d vec %0d pair", VECS[i].req, i), pair_rd_o, VECS[i].exp);
      chk($sformatf("R%0d vec %0d carry", VECS[i].req, i), {15'd0, carry_o}, {15'd0, VECS[i].exp_c});
    end
    // state: A=12 BC=1211 DE=BE00 HL=5600 carry=1

    // R7 memory destination: M <- B
    drive(C_MOVE, 8'h70, 2'd0, 16'h0, 8'h00);
    #1;
    chk("R7 write request", {14'd0, mem_wr_o, mem_rd_o}, 16'h0002);
    chk("R7 write data", {8'h00, mem_wdata_o}, 16'h0012);
    chk("R7 address", hl_addr_o, 16'h5600);
    idle_read(2'd2, 3'd7);
    chk("R7 no register write HL", pair_rd_o, 16'h5600);
    chk("R7 no register write A", {8'h00, rd_data_o}, 16'h0012);

    // R7 memory source: A <- M
    drive(C_MOVE, 8'h7E, 2'd0, 16'h0, 8'h5A);
    #1;
    chk("R7 read request", {14'd0, mem_wr_o, mem_rd_o}, 16'h0001);
    idle_read(2'd0, 3'd7);
    chk("R7 read captured", {8'h00, rd_data_o}, 16'h005A);

    // R7 collision: H <- M, address uses old HL
    drive(C_MOVE, 8'h66, 2'd0, 16'h0, 8'h77);
    #1;
    chk("R7 old address during read", hl_addr_o, 16'h5600);
    idle_read(2'd2, 3'd4);
    chk("R7 HL after H<-M", hl_addr_o, 16'h7700);

    // R8 halt opcode
    drive(C_MOVE, 8'h76, 2'd0, 16'h0, 8'h99);
    #1;
    chk("R8 halt and no request", {13'd0, halt_o, mem_rd_o, mem_wr_o}, 16'h0004);
    idle_read(2'd2, 3'd7);
    chk("R8 HL unchanged", pair_rd_o, 16'h7700);
    chk("R8 A unchanged", {8'h00, rd_data_o}, 16'h005A);
    chk("R8 halt drops", {15'd0, halt_o}, 16'h0000);

    // R1 non-move opcode under move command
    drive(C_MOVE, 8'h87, 2'd0, 16'h0, 8'h00);
    idle_read(2'd0, 3'd7);
    chk("R1 non-move ignored A", {8'h00, rd_data_o}, 16'h005A);
    chk("R1 non-move ignored BC", pair_rd_o, 16'h1211);

    // R2 code 110 reads zero, H readout
    idle_read(2'd1, 3'd6);
    chk("R2 code 110 reads 0", {8'h00, rd_data_o}, 16'h0000);
    idle_read(2'd1, 3'd4);
    chk("R2 H readout", {8'h00, rd_data_o}, 16'h0077);

    // R9 asynchronous reset between edges
    @(negedge clk);
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R9 async clear HL", hl_addr_o, 16'h0000);
    chk("R9 async clear carry", {15'd0, carry_o}, 16'h0000);
    @(negedge clk);
    rst_ni = 1'b1;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule